// File: doc/BRIEF.md
# Pulse-Activity Host Watchdog

This block supervises a host processor through a single heartbeat pin that the host's application software toggles while it judges itself healthy. The block treats every transition on that pin, rising or falling, as a sign of life. When the host stops toggling, the block pulls the host's reset line low after a programmable number of timebase ticks. The host can stop toggling because the application hangs or because the application has seen its own network or field-bus link fail.

A free-running prescaler divides the system clock into slow ticks, so a timeout of tens of seconds fits in a 16-bit count. After the reset pulse has been held for a fixed number of ticks, the block releases the line. It then allows the host a boot grace window before it starts watching the pin again. The same grace window applies after the block's own reset. A sticky flag records that a watchdog reset has taken place, and a one-cycle clear pulse lowers it again. The reset output is a plain two-level output that is always driven.

Top module: `hbwd_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `host_rst_n` is 1 and `wd_flag` is 0. The block then starts in the grace window.
- R2: The timebase ticks once every `DIV` clocks. With the heartbeat idle since reset, `host_rst_n` falls on the clock edge numbered (`GRACE_TICKS` + `tmo_ticks`) × `DIV` after reset release, where the first edge after release is edge 1.
- R3: While monitoring, any transition of `hb_in`, rising or falling, restarts the silent-tick count. A transition takes effect on the third rising clock edge after it occurs.
- R4: When the silent-tick count reaches `tmo_ticks`, `host_rst_n` goes low on that edge. It stays low for exactly `HOLD_TICKS` ticks (`HOLD_TICKS` × `DIV` clocks).
- R5: After release the block spends `GRACE_TICKS` ticks in grace. During grace, transitions are ignored and no timeout can occur. Monitoring resumes with a count of zero.
- R6: A `tmo_ticks` of 0 behaves as 1. If `tmo_ticks` is lowered to or below the count already reached, the timeout fires on the next tick.
- R7: `wd_flag` rises on the edge where `host_rst_n` falls and stays high until a `flag_clr` pulse. If a clear and a new timeout fall on the same edge, the flag stays set.
- R8: `host_rst_n` is always driven to a defined 0 or 1 and never left floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_in | input | 1 | Asynchronous heartbeat pin from the host |
| tmo_ticks | input | CNT_W | Silent ticks allowed before a host reset |
| flag_clr | input | 1 | One-cycle pulse that clears the sticky flag |
| host_rst_n | output | 1 | Push-pull active-low reset drive to the host |
| wd_flag | output | 1 | Sticky record of a watchdog-initiated reset |

## Verification
The bench builds the block with `DIV` = 4, `GRACE_TICKS` = 3 and `HOLD_TICKS` = 2. It drives `tmo_ticks` between 0 and 8. At these values a full sequence of grace, monitor, timeout, hold and release takes a few dozen clocks instead of minutes. Many complete cycles therefore fit in a short run, including timeouts changed in mid-count and heartbeats that land inside the grace window. The directed runs measure the exact edge of the first timeout and the exact length of the hold, and the random runs are compared cycle by cycle against a model in the bench.

// File: rtl/hbwd_pkg.sv
package hbwd_pkg;
  typedef enum logic [1:0] {
    ST_GRACE = 2'd0,
    ST_MON   = 2'd1,
    ST_HOLD  = 2'd2
  } wd_state_e;
endpackage

// File: rtl/hbwd_prescale.sv
// Free-running timebase: one-cycle tick every DIV clocks.
module hbwd_prescale #(
  parameter int DIV = 50000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pcnt;

  assign tick = (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/hbwd_edge_sync.sv
// Synchronizer chain plus one history flop; flags any level change.
module hbwd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic kick
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign kick = sh[STAGES-1] ^ sh[STAGES];
endmodule

// File: rtl/hbwd_fsm.sv
// Grace / monitor / hold sequencer with registered outputs.
module hbwd_fsm
  import hbwd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int GRACE_TICKS = 60000,
  parameter int HOLD_TICKS  = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             kick,
  input  logic [CNT_W-1:0] tmo,
  input  logic             flag_clr,
  output wd_state_e        st,
  output logic [CNT_W-1:0] cnt,
  output logic             host_rst_n,
  output logic             wd_flag
);
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_TICKS - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);

  wd_state_e        st_n;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    case (st)
      ST_GRACE: begin
        if (tick) begin
          if (cnt == GRACE_LAST) begin
            st_n  = ST_MON;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_inc[CNT_W-1:0];
          end
        end
      end
      ST_MON: begin
        if (kick) begin
          cnt_n = '0;
        end else if (tick) begin
          if (cnt_inc >= {1'b0, tmo}) begin
            st_n  = ST_HOLD;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_inc[CNT_W-1:0];
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          if (cnt == HOLD_LAST) begin
            st_n  = ST_GRACE;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_inc[CNT_W-1:0];
          end
        end
      end
      default: begin
        st_n  = ST_GRACE;
        cnt_n = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_GRACE;
      cnt        <= '0;
      host_rst_n <= 1'b1;
      wd_flag    <= 1'b0;
    end else begin
      st         <= st_n;
      cnt        <= cnt_n;
      host_rst_n <= (st_n != ST_HOLD);
      if (st_n == ST_HOLD && st != ST_HOLD) wd_flag <= 1'b1;
      else if (flag_clr)                    wd_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/hbwd_top.sv
module hbwd_top
  import hbwd_pkg::*;
#(
  parameter int DIV         = 50000,
  parameter int CNT_W       = 16,
  parameter int GRACE_TICKS = 60000,
  parameter int HOLD_TICKS  = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hb_in,
  input  logic [CNT_W-1:0] tmo_ticks,
  input  logic             flag_clr,
  output logic             host_rst_n,
  output logic             wd_flag
);
  logic             tick;
  logic             kick;
  wd_state_e        st;
  logic [CNT_W-1:0] cnt;

  hbwd_prescale #(.DIV(DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  hbwd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (hb_in),
    .kick     (kick)
  );

  hbwd_fsm #(
    .CNT_W       (CNT_W),
    .GRACE_TICKS (GRACE_TICKS),
    .HOLD_TICKS  (HOLD_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .kick       (kick),
    .tmo        (tmo_ticks),
    .flag_clr   (flag_clr),
    .st         (st),
    .cnt        (cnt),
    .host_rst_n (host_rst_n),
    .wd_flag    (wd_flag)
  );
endmodule

// File: rtl/hbwd_chk.sv
module hbwd_chk
  import hbwd_pkg::*;
#(
  parameter int DIV   = 50000,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             host_rst_n,
  input logic             wd_flag,
  input logic             flag_clr,
  input logic             tick,
  input logic             kick,
  input wd_state_e        st,
  input logic [CNT_W-1:0] cnt
);
  // R8
  rst_known_chk: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(host_rst_n));

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (wd_flag && !flag_clr) |=> wd_flag);

  // R7
  flag_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(host_rst_n) |-> wd_flag);

  // R4
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_rst_n && !tick) |=> !host_rst_n);

  // R5
  grace_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GRACE) |=> host_rst_n);

  // R3
  kick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MON && kick) |=> (st == ST_MON && cnt == '0));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && tick) |=> !tick);
endmodule

bind hbwd_top hbwd_chk #(.DIV(DIV), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_rst_n (host_rst_n),
  .wd_flag    (wd_flag),
  .flag_clr   (flag_clr),
  .tick       (tick),
  .kick       (kick),
  .st         (st),
  .cnt        (cnt)
);

// File: tb/hbwd_top_bench.sv
`timescale 1ns/1ps
module hbwd_top_bench;
  localparam int DIV   = 4;
  localparam int GRACE = 3;
  localparam int HOLD  = 2;
  localparam int CW    = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          hb  = 1'b0;
  logic [CW-1:0] tmo = 16'd5;
  logic          clr = 1'b0;
  logic          host_rst_n;
  logic          wd_flag;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hbwd_top #(.DIV(DIV), .CNT_W(CW), .GRACE_TICKS(GRACE), .HOLD_TICKS(HOLD)) u_hbwd_top (
    .clk(clk), .rst(rst), .hb_in(hb), .tmo_ticks(tmo), .flag_clr(clr),
    .host_rst_n(host_rst_n), .wd_flag(wd_flag)
  );

  // expected edge index of the first timeout with an idle heartbeat
  function automatic int first_fall(input int t);
    int te = (t == 0) ? 1 : t;
    return (GRACE + te) * DIV;
  endfunction

  function automatic int hold_len();
    return HOLD * DIV;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, stepped on every rising edge
  int  pc, m_st, m_cnt;
  bit  h1, h2, h3, e_rst_n, e_flag, live;
  always @(posedge clk) begin
    bit kk, tk, enter;
    if (rst) begin
      pc = 0; h1 = 0; h2 = 0; h3 = 0; m_st = 0; m_cnt = 0;
      e_rst_n = 1; e_flag = 0; live = 0;
    end else begin
      live = 1;
      kk = (h2 != h3);
      h3 = h2; h2 = h1; h1 = hb;
      pc++;
      tk = (pc % DIV == 0);
      enter = 0;
      if (m_st == 0) begin
        if (tk) begin
          if (m_cnt == GRACE - 1) begin m_st = 1; m_cnt = 0; end
          else m_cnt++;
        end
      end else if (m_st == 1) begin
        if (kk) m_cnt = 0;
        else if (tk) begin
          if (m_cnt + 1 >= int'(tmo)) begin m_st = 2; m_cnt = 0; enter = 1; end
          else m_cnt++;
        end
      end else begin
        if (tk) begin
          if (m_cnt == HOLD - 1) begin m_st = 0; m_cnt = 0; end
          else m_cnt++;
        end
      end
      e_rst_n = (m_st != 2);
      if (enter) e_flag = 1;
      else if (clr) e_flag = 0;
    end
  end

  // cycle-by-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (live && !done) begin
      check(host_rst_n === e_rst_n, "R2 R3 R4 R5 R6 host_rst_n", int'(host_rst_n), int'(e_rst_n));
      check(wd_flag === e_flag, "R7 wd_flag", int'(wd_flag), int'(e_flag));
      check(host_rst_n === 1'b0 || host_rst_n === 1'b1, "R8 defined drive", int'(host_rst_n), 1);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; hb = 1'b0; clr = 1'b0;
    repeat (3) @(negedge clk);
    check(host_rst_n === 1'b1, "R1 rst_n in reset", int'(host_rst_n), 1);
    check(wd_flag === 1'b0, "R1 flag in reset", int'(wd_flag), 0);
    rst = 1'b0;
  endtask

  task automatic measure(input int t, input string req);
    int n = 0, l = 0;
    tmo = CW'(t);
    do_reset();
    while (host_rst_n !== 1'b0 && n < 2000) begin
      @(negedge clk); n++;
      if (n == 1) begin
        check(host_rst_n === 1'b1, "R1 rst_n after release", int'(host_rst_n), 1);
        check(wd_flag === 1'b0, "R1 flag after release", int'(wd_flag), 0);
      end
    end
    check(n == first_fall(t), req, n, first_fall(t));
    l = 1;
    while (l < 2000) begin
      @(negedge clk);
      if (host_rst_n === 1'b0) l++; else break;
    end
    check(l == hold_len(), "R4 hold length", l, hold_len());
    check(wd_flag === 1'b1, "R7 flag set", int'(wd_flag), 1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    @(negedge clk);
    check(wd_flag === 1'b0, "R7 flag cleared", int'(wd_flag), 0);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    // R1 R2 R4: idle heartbeat, exact timing
    measure(5, "R2 first timeout edge");
    // R6: zero timeout acts as one tick
    measure(0, "R6 zero timeout edge");
    // R3: toggle steadily inside the window; no reset for many windows
    tmo = 16'd3; do_reset();
    repeat (GRACE * DIV + 4) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      hb = ~hb;
      repeat (DIV * 2) @(negedge clk);
    end
    check(host_rst_n === 1'b1, "R3 kicks keep host alive", int'(host_rst_n), 1);
    // R6: lower the timeout below the elapsed count
    tmo = 16'd20; do_reset();
    repeat ((GRACE + 4) * DIV) @(negedge clk);
    tmo = 16'd1;
    repeat (DIV + 1) @(negedge clk);
    check(host_rst_n === 1'b0, "R6 lowered timeout fires", int'(host_rst_n), 0);
    // R5 R7: random heartbeat, timeout and clear traffic against the model
    do_reset();
    for (int seg = 0; seg < 120; seg++) begin
      int len  = 5 + int'($urandom_range(60));
      bit busy = ($urandom_range(2) != 0);
      int gap  = 1 + int'($urandom_range(DIV * 3));
      if ($urandom_range(5) == 0) tmo = CW'($urandom_range(8));
      for (int c = 0; c < len; c++) begin
        if (busy && (c % gap == 0)) hb = ~hb;
        clr = ($urandom_range(15) == 0);
        @(negedge clk);
      end
    end
    clr = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule